// File: doc/BRIEF.md
# Horizontal Microcode Sequencer

This block is the control sequencer of a microcoded processor. A clocked microcode store of 256 words, each 72 bits wide, holds one horizontal microword per step. The registered output word drives the datapath controls directly. These controls are the two ALU operand selects, the ALU operation code, an inline 16-bit literal, a vector of register load strobes and a byte of spare control bits. No decoding stage sits between the store and the datapath, apart from two flags that mark the literal as the chosen operand.

Each word also says where to go next. It carries a plain successor address, an alternative branch-target address, a call-return target and a 4-bit branch code. The branch code can pick the successor or the branch target, test one of twelve condition inputs, return through a single saved return address, or jump to an opcode entry point supplied from outside. The store has one cycle of read latency. For that reason, the following address is formed combinationally from the word now on the outputs, the conditions and the dispatch input, and it goes straight to the store address in the same cycle.

Top module: `wide_useq`

## Requirements
- R1: While `rst_i` is high, `upc_o`, `ld_en_o` and `ret_o` read zero. In the first cycle after `rst_i` falls they still read zero, and the word at microaddress 0 appears on the outputs one clock later.
- R2: Outside the reset bubble, the outputs carry the fields of the microword at `upc_o`. Word bits are [2:0] operand-1 select, [7:3] operand-2 select, [11:8] ALU code, [27:12] literal, [35:28] successor, [43:36] branch target, [51:44] return target, [55:52] branch code, [63:56] load strobes (bit0 PC, bit1 write-data, bit2 temp 1, bit3 temp 2, bit4 effective address, bits 5 to 7 spare), and [71:64] spare controls.
- R3: `lit_to_a_o` is high exactly when the operand-1 select is 7. `lit_to_b_o` is high exactly when the operand-2 select is 31.
- R4: Branch code 0 makes the successor field the next `upc_o`.
- R5: Branch code 1 makes the branch-target field the next `upc_o`.
- R6: Branch codes 2 to 13 test `cond_i[code-2]`. If that bit is high, the branch target is the next `upc_o`; otherwise the successor is.
- R7: Branch code 14 makes the saved return address (`ret_o`) the next `upc_o`.
- R8: Branch code 15 makes `dispatch_i` the next `upc_o`.
- R9: A word whose return-target field is nonzero and whose branch code is not 14 is a call: `ret_o` takes that field on the next clock. Every other word leaves `ret_o` unchanged.
- R10: The default store image for address a is: operand-1 = a mod 8, operand-2 = a div 8, ALU = (a mod 16) xor (a div 16), literal = {a, ~a}, successor = a+1, branch target = nibble-swapped a xor 0x3C, return target = a+16 when a mod 8 = 3 (else 0), branch code = a mod 16, loads = a xor 0x5A, spare = ~a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cond_i | input | 12 | Condition flags tested by branch codes 2 to 13 |
| dispatch_i | input | 8 | Opcode entry microaddress used by branch code 15 |
| upc_o | output | 8 | Microaddress of the word now on the outputs |
| ret_o | output | 8 | Saved microsubroutine return address |
| opa_sel_o | output | 3 | ALU operand-1 select |
| opb_sel_o | output | 5 | ALU operand-2 select |
| alu_op_o | output | 4 | ALU operation code |
| literal_o | output | 16 | Inline literal constant |
| lit_to_a_o | output | 1 | Operand-1 select names the literal |
| lit_to_b_o | output | 1 | Operand-2 select names the literal |
| ld_en_o | output | 8 | Register load strobes |
| ext_o | output | 8 | Spare control bits |

## Verification
The assertions assume that `cond_i` and `dispatch_i` are steady and known around each rising edge. They also assume that reset is synchronous and lasts at least one clock. The bench meets this by changing the inputs only on falling edges and by holding reset for several clocks. Because every address in the 8-bit space holds a defined word, any dispatch value is legal. The bench therefore draws conditions and dispatch targets freely and follows the resulting walk through the store. It breaks the walk once with a mid-run reset that must also clear the saved return address.

// File: rtl/wide_useq_pkg.sv
package wide_useq_pkg;
  localparam int UA_W   = 8;
  localparam int UW_W   = 72;
  localparam int BR_W   = 4;
  localparam int NCOND  = (1 << BR_W) - 4;
  localparam int LD_W   = 8;
  localparam int LIT_W  = 16;
  localparam int OPA_W  = 3;
  localparam int OPB_W  = 5;
  localparam int ALU_W  = 4;
  localparam int EXT_W  = UW_W - (LD_W + BR_W + 3*UA_W + LIT_W + ALU_W + OPB_W + OPA_W);
  localparam int DEPTH  = 1 << UA_W;

  localparam logic [BR_W-1:0] BR_NEXT    = BR_W'(0);
  localparam logic [BR_W-1:0] BR_ALT     = BR_W'(1);
  localparam logic [BR_W-1:0] BR_TEST_LO = BR_W'(2);
  localparam logic [BR_W-1:0] BR_RET     = BR_W'(14);
  localparam logic [BR_W-1:0] BR_DISP    = BR_W'(15);

  localparam logic [OPA_W-1:0] OPA_LIT = '1;
  localparam logic [OPB_W-1:0] OPB_LIT = '1;

  typedef struct packed {
    logic [EXT_W-1:0] ext;
    logic [LD_W-1:0]  ld;
    logic [BR_W-1:0]  br;
    logic [UA_W-1:0]  ret;
    logic [UA_W-1:0]  alt;
    logic [UA_W-1:0]  nxt;
    logic [LIT_W-1:0] lit;
    logic [ALU_W-1:0] alu;
    logic [OPB_W-1:0] opb;
    logic [OPA_W-1:0] opa;
  } uword_t;

  // Default store image, one word per microaddress.
  function automatic uword_t image_word(input logic [UA_W-1:0] a);
    uword_t w;
    w      = '0;
    w.opa  = a[2:0];
    w.opb  = a[7:3];
    w.alu  = a[3:0] ^ a[7:4];
    w.lit  = {a, ~a};
    w.nxt  = a + 8'd1;
    w.alt  = {a[3:0], a[7:4]} ^ 8'h3C;
    w.ret  = (a[2:0] == 3'd3) ? a + 8'd16 : 8'd0;
    w.br   = a[3:0];
    w.ld   = a ^ 8'h5A;
    w.ext  = ~a;
    return w;
  endfunction

  // Selection of the following microaddress.
  function automatic logic [UA_W-1:0] pick_next(
      input logic [BR_W-1:0]  br,
      input logic [UA_W-1:0]  nxt,
      input logic [UA_W-1:0]  alt,
      input logic [NCOND-1:0] cond,
      input logic [UA_W-1:0]  disp,
      input logic [UA_W-1:0]  saved);
    logic [BR_W-1:0] idx;
    idx = br - BR_TEST_LO;
    case (br)
      BR_NEXT: return nxt;
      BR_ALT:  return alt;
      BR_RET:  return saved;
      BR_DISP: return disp;
      default: return cond[idx] ? alt : nxt;
    endcase
  endfunction

  function automatic logic is_call(input logic [BR_W-1:0] br, input logic [UA_W-1:0] ret);
    return (ret != '0) && (br != BR_RET);
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import wide_useq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [UA_W-1:0] addr_i,
  output uword_t          word_o
);
  uword_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = image_word(UA_W'(i));
  end

  // Registered read; reset loads an all-zero word (no loads, successor 0).
  always_ff @(posedge clk_i) begin
    if (rst_i) word_o <= '0;
    else       word_o <= mem[addr_i];
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import wide_useq_pkg::*;
(
  input  logic [BR_W-1:0]  br_i,
  input  logic [UA_W-1:0]  nxt_i,
  input  logic [UA_W-1:0]  alt_i,
  input  logic [UA_W-1:0]  ret_field_i,
  input  logic [NCOND-1:0] cond_i,
  input  logic [UA_W-1:0]  dispatch_i,
  input  logic [UA_W-1:0]  saved_i,
  output logic [UA_W-1:0]  next_addr_o,
  output logic             call_o
);
  always_comb begin
    next_addr_o = pick_next(br_i, nxt_i, alt_i, cond_i, dispatch_i, saved_i);
    call_o      = is_call(br_i, ret_field_i);
  end
endmodule

// File: rtl/useq_retreg.sv
module useq_retreg
  import wide_useq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            call_i,
  input  logic [UA_W-1:0] ret_field_i,
  output logic [UA_W-1:0] saved_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)       saved_o <= '0;
    else if (call_i) saved_o <= ret_field_i;
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import wide_useq_pkg::*;
(
  input  logic [OPA_W-1:0] opa_i,
  input  logic [OPB_W-1:0] opb_i,
  input  logic [ALU_W-1:0] alu_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic [LD_W-1:0]  ld_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic [OPA_W-1:0] opa_o,
  output logic [OPB_W-1:0] opb_o,
  output logic [ALU_W-1:0] alu_o,
  output logic [LIT_W-1:0] lit_o,
  output logic             lit_a_o,
  output logic             lit_b_o,
  output logic [LD_W-1:0]  ld_o,
  output logic [EXT_W-1:0] ext_o
);
  always_comb begin
    opa_o   = opa_i;
    opb_o   = opb_i;
    alu_o   = alu_i;
    lit_o   = lit_i;
    ld_o    = ld_i;
    ext_o   = ext_i;
    lit_a_o = (opa_i == OPA_LIT);
    lit_b_o = (opb_i == OPB_LIT);
  end
endmodule

// File: rtl/wide_useq.sv
module wide_useq
  import wide_useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NCOND-1:0] cond_i,
  input  logic [UA_W-1:0]  dispatch_i,
  output logic [UA_W-1:0]  upc_o,
  output logic [UA_W-1:0]  ret_o,
  output logic [OPA_W-1:0] opa_sel_o,
  output logic [OPB_W-1:0] opb_sel_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic [LIT_W-1:0] literal_o,
  output logic             lit_to_a_o,
  output logic             lit_to_b_o,
  output logic [LD_W-1:0]  ld_en_o,
  output logic [EXT_W-1:0] ext_o
);
  uword_t          cur_w;
  logic [UA_W-1:0] next_addr;
  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] saved_q;
  logic            call;

  useq_rom u_rom (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .addr_i (next_addr),
    .word_o (cur_w)
  );

  useq_next u_next (
    .br_i        (cur_w.br),
    .nxt_i       (cur_w.nxt),
    .alt_i       (cur_w.alt),
    .ret_field_i (cur_w.ret),
    .cond_i      (cond_i),
    .dispatch_i  (dispatch_i),
    .saved_i     (saved_q),
    .next_addr_o (next_addr),
    .call_o      (call)
  );

  useq_retreg u_ret (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .call_i      (call),
    .ret_field_i (cur_w.ret),
    .saved_o     (saved_q)
  );

  // Address of the word held in the store output register.
  always_ff @(posedge clk_i) begin
    if (rst_i) upc_q <= '0;
    else       upc_q <= next_addr;
  end

  useq_decode u_dec (
    .opa_i   (cur_w.opa),
    .opb_i   (cur_w.opb),
    .alu_i   (cur_w.alu),
    .lit_i   (cur_w.lit),
    .ld_i    (cur_w.ld),
    .ext_i   (cur_w.ext),
    .opa_o   (opa_sel_o),
    .opb_o   (opb_sel_o),
    .alu_o   (alu_op_o),
    .lit_o   (literal_o),
    .lit_a_o (lit_to_a_o),
    .lit_b_o (lit_to_b_o),
    .ld_o    (ld_en_o),
    .ext_o   (ext_o)
  );

  assign upc_o = upc_q;
  assign ret_o = saved_q;
endmodule

// File: rtl/wide_useq_chk.sv
module wide_useq_chk
  import wide_useq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_i,
  input logic [NCOND-1:0] cond_i,
  input logic [UA_W-1:0]  dispatch_i,
  input logic [UA_W-1:0]  upc_o,
  input logic [UA_W-1:0]  ret_o,
  input logic [LD_W-1:0]  ld_en_o,
  input uword_t           cur_w,
  input logic [UA_W-1:0]  next_addr,
  input logic             call
);
  a_r1_reset_bubble: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (ld_en_o == '0 && upc_o == '0 && ret_o == '0));

  a_r2_addr_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (upc_o == $past(next_addr)));

  a_r2_word_matches: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (cur_w == image_word(upc_o)));

  a_r4_successor: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_w.br == BR_NEXT) |=> (upc_o == $past(cur_w.nxt)));

  a_r5_branch_always: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_w.br == BR_ALT) |=> (upc_o == $past(cur_w.alt)));

  a_r6_cond_true: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_w.br >= BR_TEST_LO && cur_w.br < BR_RET && cond_i[cur_w.br - BR_TEST_LO])
      |=> (upc_o == $past(cur_w.alt)));

  a_r6_cond_false: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_w.br >= BR_TEST_LO && cur_w.br < BR_RET && !cond_i[cur_w.br - BR_TEST_LO])
      |=> (upc_o == $past(cur_w.nxt)));

  a_r7_return: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_w.br == BR_RET) |=> (upc_o == $past(ret_o)));

  a_r8_dispatch: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_w.br == BR_DISP) |=> (upc_o == $past(dispatch_i)));

  a_r9_call_saves: assert property (@(posedge clk_i) disable iff (rst_i)
    call |=> (ret_o == $past(cur_w.ret)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !call |=> $stable(ret_o));
endmodule

bind wide_useq wide_useq_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .cond_i     (cond_i),
  .dispatch_i (dispatch_i),
  .upc_o      (upc_o),
  .ret_o      (ret_o),
  .ld_en_o    (ld_en_o),
  .cur_w      (cur_w),
  .next_addr  (next_addr),
  .call       (call)
);

// File: tb/wide_useq_tb.sv
`timescale 1ns/1ps
module wide_useq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cond = '0;
  logic [7:0]  disp = '0;
  logic [7:0]  upc_o, ret_o, ld_en_o, ext_o;
  logic [2:0]  opa_sel_o;
  logic [4:0]  opb_sel_o;
  logic [3:0]  alu_op_o;
  logic [15:0] literal_o;
  logic        lit_to_a_o, lit_to_b_o;

  always #10 clk = ~clk;

  wide_useq u_dut (
    .clk_i(clk), .rst_i(rst), .cond_i(cond), .dispatch_i(disp),
    .upc_o(upc_o), .ret_o(ret_o), .opa_sel_o(opa_sel_o), .opb_sel_o(opb_sel_o),
    .alu_op_o(alu_op_o), .literal_o(literal_o), .lit_to_a_o(lit_to_a_o),
    .lit_to_b_o(lit_to_b_o), .ld_en_o(ld_en_o), .ext_o(ext_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  int    m_upc, m_ret;
  bit    m_bub;
  string m_tag;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Store image restated from R10 in plain arithmetic.
  function automatic int f_succ(int a);  return (a + 1) % 256; endfunction
  function automatic int f_alt(int a);   return ((a % 16) * 16 + a / 16) ^ 60; endfunction
  function automatic int f_ret(int a);   return (a % 8 == 3) ? (a + 16) % 256 : 0; endfunction

  task automatic observe();
    if (m_bub) begin
      check("R1", int'(upc_o), 0);
      check("R1", int'(ld_en_o), 0);
    end else begin
      check(m_tag, int'(upc_o), m_upc);
      check("R2", int'(opa_sel_o), m_upc % 8);
      check("R2", int'(opb_sel_o), m_upc / 8);
      check("R2", int'(alu_op_o), (m_upc % 16) ^ (m_upc / 16));
      check("R2", int'(literal_o), m_upc * 256 + 255 - m_upc);
      check("R2", int'(ld_en_o), m_upc ^ 90);
      check("R2", int'(ext_o), 255 - m_upc);
      check("R3", int'(lit_to_a_o), (m_upc % 8 == 7) ? 1 : 0);
      check("R3", int'(lit_to_b_o), (m_upc / 8 == 31) ? 1 : 0);
    end
    check("R9", int'(ret_o), m_ret);
  endtask

  task automatic step();
    int a, br, n;
    cond = 12'($urandom);
    disp = 8'($urandom);
    if (m_bub) begin
      n = 0; m_tag = "R1";
    end else begin
      a  = m_upc;
      br = a % 16;
      if (br == 0)       begin n = f_succ(a); m_tag = "R4"; end
      else if (br == 1)  begin n = f_alt(a);  m_tag = "R5"; end
      else if (br <= 13) begin n = cond[br-2] ? f_alt(a) : f_succ(a); m_tag = "R6"; end
      else if (br == 14) begin n = m_ret; m_tag = "R7"; end
      else               begin n = int'(disp); m_tag = "R8"; end
      if (f_ret(a) != 0 && br != 14) m_ret = f_ret(a);
    end
    m_upc = n;
    m_bub = 0;
    @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    repeat (n) begin
      @(negedge clk);
      check("R1", int'(upc_o), 0);
      check("R1", int'(ld_en_o), 0);
      check("R1", int'(ret_o), 0);
    end
    rst   = 1'b0;
    m_upc = 0;
    m_ret = 0;
    m_bub = 1;
  endtask

  initial begin
    do_reset(3);
    repeat (2000) begin observe(); step(); end
    do_reset(2);
    repeat (1500) begin observe(); step(); end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule